// File: doc/BRIEF.md
# ECC Error Injection and Capture

This block sits between a memory controller's datapath and its ECC encoder/decoder. On the write path it can flip chosen data and check bits by XOR masks. This lets test software plant known faults in memory and then watch the decoder react. Corruption happens only while a global enable bit is set. Clearing the three injection registers turns it off.

On the read path the block watches the decoder's single-bit and multi-bit error flags. It records the first failing transaction: the 64 data bits, the check byte, the address, the extended address and the attribute word. That record stays frozen until software clears the error flags. A second error that arrives while the record is frozen only raises an overflow flag.

A detect register collects these flags together with three other error events from the controller. Its bits are cleared by writing ones to them. A saturating counter tallies single-bit errors. An interrupt line stays high while any detect bit is set. All state is reached through a simple 32-bit register port whose read data appears one cycle after the request.

Top module: `ecc_inject_capture`

## Requirements
- R1: While the enable bit (bit 31 of the control register at word offset 2) is 0, `wr_data_out` equals `wr_data_in` and `wr_chk_out` equals `wr_chk_in`. This holds even when masks are loaded, and also when all three injection registers are written with zero.
- R2: While the enable bit is 1, the write-path outputs are XOR-corrupted. `wr_data_out[63:32]` is `wr_data_in[63:32]` XOR the upper mask (offset 0). `wr_data_out[31:0]` is `wr_data_in[31:0]` XOR the lower mask (offset 1). `wr_chk_out` is `wr_chk_in` XOR the check mask held in bits 7:0 of the control register.
- R3: A read request (`reg_en`=1, `reg_we`=0) returns its data on `reg_rdata` in the following cycle, and `reg_rdata` holds that value until the next read. The injection registers read back what was written. Offsets 11 to 15 read as zero.
- R4: When `rd_valid` is high with `rd_sbe` or `rd_mbe`, and no capture is frozen, the block records the transaction. The record is read at these offsets: upper data at 5, lower data at 6, check byte at 7, address at 8, extended address (4 bits) at 9 and attributes at 10.
- R5: The record is frozen while detect bit 2 or bit 3 is set. A further error during that time leaves the record unchanged and sets detect bit 31.
- R6: The detect register sits at offset 4's neighbour, offset 3. A single-bit error with no multi-bit flag sets bit 2. A multi-bit error sets bit 3 and not bit 2. Pulses on `ev_addr_par`, `ev_calib` and `ev_sel` set bits 8, 7 and 0. Writing a one clears a bit, writing a zero leaves it unchanged, and a new event in the same cycle as a clear wins.
- R7: The single-bit counter sits in the low 8 bits of offset 4. It counts single-bit errors that have no multi-bit flag, stops at 0xFF without wrapping, and is loaded with `reg_wdata[7:0]` when written, so writing zero clears it.
- R8: `irq` is high exactly while any detect bit is set, and stays high until every set bit has been cleared.
- R9: After reset, every register reads zero, `irq` is low and no injection takes place.
- R10: After detect bits 2 and 3 have been cleared, the next error is recorded again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_data_in | input | 64 | Write data from the encoder side |
| wr_chk_in | input | 8 | Check byte from the encoder |
| wr_data_out | output | 64 | Write data toward memory, possibly corrupted |
| wr_chk_out | output | 8 | Check byte toward memory, possibly corrupted |
| rd_valid | input | 1 | Read result from the decoder is valid this cycle |
| rd_sbe | input | 1 | Decoder found a correctable single-bit error |
| rd_mbe | input | 1 | Decoder found an uncorrectable multi-bit error |
| rd_data | input | 64 | Raw data of the read transaction |
| rd_chk | input | 8 | Raw check byte of the read transaction |
| rd_addr | input | 32 | Address of the read transaction |
| rd_ext_addr | input | 4 | Extended address bits of the read |
| rd_attr | input | 32 | Attribute word of the read transaction |
| ev_addr_par | input | 1 | Address parity error pulse |
| ev_calib | input | 1 | Calibration error pulse |
| ev_sel | input | 1 | Memory select error pulse |
| reg_en | input | 1 | Register access request |
| reg_we | input | 1 | 1 for write, 0 for read |
| reg_addr | input | 4 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after the request |
| irq | output | 1 | Error interrupt |

## Verification
The bench builds the block with its default parameters: 64 data bits split into two 32-bit halves, an 8-bit check byte and an 8-bit counter. With an 8-bit counter, saturation at 0xFF is reached in a few hundred error pulses, which puts the no-wrap corner within a short run. With 32-bit halves, every mask and capture field lines up with the register port, so each field is read back in full. A behavioural model predicts the write-path outputs, `irq` and `reg_rdata` in every cycle. Directed reads confirm freezing, overflow, the write-one-to-clear behaviour and re-arming.

// File: rtl/eic_pkg.sv
// Package: shared register offsets and detect-bit positions for the
// ECC error injection and capture block.
// Assumes a 32-bit register port and a 4-bit word offset.
package eic_pkg;

    localparam int REG_W = 32;

    // Word offsets of the register map
    typedef enum logic [3:0] {
        OFS_INJ_HI   = 4'd0,
        OFS_INJ_LO   = 4'd1,
        OFS_INJ_CTL  = 4'd2,
        OFS_DETECT   = 4'd3,
        OFS_SBE_CNT  = 4'd4,
        OFS_CAP_HI   = 4'd5,
        OFS_CAP_LO   = 4'd6,
        OFS_CAP_CHK  = 4'd7,
        OFS_CAP_ADDR = 4'd8,
        OFS_CAP_EXT  = 4'd9,
        OFS_CAP_ATTR = 4'd10
    } reg_ofs_e;

    // Detect register bit positions
    localparam int DET_OVF      = 31;
    localparam int DET_ADDR_PAR = 8;
    localparam int DET_CALIB    = 7;
    localparam int DET_MBE      = 3;
    localparam int DET_SBE      = 2;
    localparam int DET_SEL      = 0;

    // Position of the injection enable in the control register
    localparam int CTL_EN_BIT = 31;

    // Bits of the detect register that can ever be set
    localparam logic [REG_W-1:0] DET_DEFINED =
        (REG_W'(1) << DET_OVF) | (REG_W'(1) << DET_ADDR_PAR) |
        (REG_W'(1) << DET_CALIB) | (REG_W'(1) << DET_MBE) |
        (REG_W'(1) << DET_SBE) | (REG_W'(1) << DET_SEL);

endpackage

// File: rtl/eic_inject.sv
// Module: write-path fault injection.
// Holds the upper and lower data masks and the check mask with its enable,
// and XORs the masks into the outgoing write data while enabled.
// Assumes DATA_W is twice REG_W's usable half and CHK_W < REG_W.
module eic_inject
    import eic_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic [AW-1:0]     reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CHK_W-1:0]  chk_in,
    output logic [DATA_W-1:0] data_out,
    output logic [CHK_W-1:0]  chk_out,
    output logic [DATA_W-1:0] data_mask,
    output logic [CHK_W-1:0]  chk_mask,
    output logic              inj_en
);

    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] eff_data_mask;
    logic [CHK_W-1:0]  eff_chk_mask;

    // One mask register per data half; index 1 is the upper half
    for (genvar g = 0; g < 2; g++) begin : g_half
        localparam logic [AW-1:0] HALF_OFS =
            (g == 1) ? AW'(OFS_INJ_HI) : AW'(OFS_INJ_LO);
        logic [HALF_W-1:0] mask_q;

        // Load this half's mask on a register write to its offset
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask_q <= '0;
            else if (wr_stb && reg_addr == HALF_OFS)
                mask_q <= reg_wdata[HALF_W-1:0];
        end

        assign data_mask[g*HALF_W +: HALF_W] = mask_q;
    end

    // Control register: enable bit and check-byte mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inj_en   <= 1'b0;
            chk_mask <= '0;
        end else if (wr_stb && reg_addr == AW'(OFS_INJ_CTL)) begin
            inj_en   <= reg_wdata[CTL_EN_BIT];
            chk_mask <= reg_wdata[CHK_W-1:0];
        end
    end

    // Gate the masks with the enable and corrupt the write path
    always_comb begin
        eff_data_mask = inj_en ? data_mask : '0;
        eff_chk_mask  = inj_en ? chk_mask  : '0;
        data_out      = data_in ^ eff_data_mask;
        chk_out       = chk_in  ^ eff_chk_mask;
    end

endmodule

// File: rtl/eic_status.sv
// Module: detect register, single-bit error counter and interrupt.
// Detect bits are set by events and cleared by writing ones; a set in the
// same cycle as a clear wins. The counter saturates at all ones.
// Assumes err_sbe/err_mbe are already qualified by the read-valid strobe.
module eic_status
    import eic_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              err_sbe,
    input  logic              err_mbe,
    input  logic              ev_addr_par,
    input  logic              ev_calib,
    input  logic              ev_sel,
    input  logic              det_clr_we,
    input  logic [REG_W-1:0]  det_clr_mask,
    input  logic              cnt_we,
    input  logic [CNT_W-1:0]  cnt_wdata,
    output logic [REG_W-1:0]  det_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              frozen,
    output logic              irq
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [REG_W-1:0] set_v;
    logic [REG_W-1:0] clr_v;
    logic             count_hit;

    assign frozen = det_q[DET_SBE] | det_q[DET_MBE];
    assign irq    = |det_q;

    // Build the set and clear vectors for this cycle
    always_comb begin
        set_v = '0;
        if (err_mbe)
            set_v[DET_MBE] = 1'b1;
        else if (err_sbe)
            set_v[DET_SBE] = 1'b1;
        if ((err_mbe || err_sbe) && frozen)
            set_v[DET_OVF] = 1'b1;
        set_v[DET_ADDR_PAR] = ev_addr_par;
        set_v[DET_CALIB]    = ev_calib;
        set_v[DET_SEL]      = ev_sel;
        clr_v     = det_clr_we ? (det_clr_mask & DET_DEFINED) : '0;
        count_hit = err_sbe && !err_mbe && (cnt_q != CNT_MAX);
    end

    // Detect register update: clear first, then set
    always_ff @(posedge clk) begin
        if (!rst_n)
            det_q <= '0;
        else
            det_q <= (det_q & ~clr_v) | set_v;
    end

    // Saturating single-bit error counter; a software write takes priority
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (cnt_we)
            cnt_q <= cnt_wdata;
        else if (count_hit)
            cnt_q <= cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/eic_capture.sv
// Module: first-error capture registers.
// Loads the failing transaction when cap_en is high; holds otherwise.
// Assumes the caller suppresses cap_en while a capture is frozen.
module eic_capture #(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8,
    parameter int ADDR_W = 32,
    parameter int EXT_W  = 4,
    parameter int ATTR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] data_in,
    input  logic [CHK_W-1:0]  chk_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [EXT_W-1:0]  ext_in,
    input  logic [ATTR_W-1:0] attr_in,
    output logic [DATA_W-1:0] cap_data,
    output logic [CHK_W-1:0]  cap_chk,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [EXT_W-1:0]  cap_ext,
    output logic [ATTR_W-1:0] cap_attr
);

    // Record the whole transaction in one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_data <= '0;
            cap_chk  <= '0;
            cap_addr <= '0;
            cap_ext  <= '0;
            cap_attr <= '0;
        end else if (cap_en) begin
            cap_data <= data_in;
            cap_chk  <= chk_in;
            cap_addr <= addr_in;
            cap_ext  <= ext_in;
            cap_attr <= attr_in;
        end
    end

endmodule

// File: rtl/eic_readmux.sv
// Module: registered read-back multiplexer for the register port.
// Selects a register by word offset; unmapped offsets return zero.
// The output holds its value between reads.
module eic_readmux
    import eic_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8,
    parameter int ADDR_W = 32,
    parameter int EXT_W  = 4,
    parameter int ATTR_W = 32,
    parameter int CNT_W  = 8,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DATA_W-1:0] data_mask,
    input  logic [CHK_W-1:0]  chk_mask,
    input  logic              inj_en,
    input  logic [REG_W-1:0]  det_q,
    input  logic [CNT_W-1:0]  cnt_q,
    input  logic [DATA_W-1:0] cap_data,
    input  logic [CHK_W-1:0]  cap_chk,
    input  logic [ADDR_W-1:0] cap_addr,
    input  logic [EXT_W-1:0]  cap_ext,
    input  logic [ATTR_W-1:0] cap_attr,
    output logic [REG_W-1:0]  rdata_q
);

    localparam int HALF_W = DATA_W / 2;

    logic [REG_W-1:0] sel_v;
    logic [REG_W-1:0] ctl_v;

    // Assemble the control word and pick the addressed register
    always_comb begin
        ctl_v             = REG_W'(chk_mask);
        ctl_v[CTL_EN_BIT] = inj_en;
        case (reg_addr)
            AW'(OFS_INJ_HI):   sel_v = REG_W'(data_mask[DATA_W-1:HALF_W]);
            AW'(OFS_INJ_LO):   sel_v = REG_W'(data_mask[HALF_W-1:0]);
            AW'(OFS_INJ_CTL):  sel_v = ctl_v;
            AW'(OFS_DETECT):   sel_v = det_q;
            AW'(OFS_SBE_CNT):  sel_v = REG_W'(cnt_q);
            AW'(OFS_CAP_HI):   sel_v = REG_W'(cap_data[DATA_W-1:HALF_W]);
            AW'(OFS_CAP_LO):   sel_v = REG_W'(cap_data[HALF_W-1:0]);
            AW'(OFS_CAP_CHK):  sel_v = REG_W'(cap_chk);
            AW'(OFS_CAP_ADDR): sel_v = REG_W'(cap_addr);
            AW'(OFS_CAP_EXT):  sel_v = REG_W'(cap_ext);
            AW'(OFS_CAP_ATTR): sel_v = REG_W'(cap_attr);
            default:           sel_v = '0;
        endcase
    end

    // Register the selected word on a read request
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_stb)
            rdata_q <= sel_v;
    end

endmodule

// File: rtl/ecc_inject_capture.sv
// Module: top of the ECC error injection and capture block.
// Write path: XOR fault injection. Read path: first-error capture,
// detect flags, single-bit counter and interrupt, all on a 32-bit
// register port with one cycle of read latency.
// Assumes a single register access per cycle and a synchronous reset.
module ecc_inject_capture
    import eic_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8,
    parameter int ADDR_W = 32,
    parameter int EXT_W  = 4,
    parameter int ATTR_W = 32,
    parameter int CNT_W  = 8,
    parameter int AW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] wr_data_in,
    input  logic [CHK_W-1:0]  wr_chk_in,
    output logic [DATA_W-1:0] wr_data_out,
    output logic [CHK_W-1:0]  wr_chk_out,
    input  logic              rd_valid,
    input  logic              rd_sbe,
    input  logic              rd_mbe,
    input  logic [DATA_W-1:0] rd_data,
    input  logic [CHK_W-1:0]  rd_chk,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [EXT_W-1:0]  rd_ext_addr,
    input  logic [ATTR_W-1:0] rd_attr,
    input  logic              ev_addr_par,
    input  logic              ev_calib,
    input  logic              ev_sel,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [AW-1:0]     reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);

    logic              wr_stb;
    logic              rd_stb;
    logic              err_sbe_w;
    logic              err_mbe_w;
    logic              frozen_w;
    logic              cap_en_w;
    logic              inj_en_w;
    logic [DATA_W-1:0] data_mask_w;
    logic [CHK_W-1:0]  chk_mask_w;
    logic [REG_W-1:0]  det_w;
    logic [CNT_W-1:0]  cnt_w;
    logic [DATA_W-1:0] cap_data_w;
    logic [CHK_W-1:0]  cap_chk_w;
    logic [ADDR_W-1:0] cap_addr_w;
    logic [EXT_W-1:0]  cap_ext_w;
    logic [ATTR_W-1:0] cap_attr_w;

    // Access strobes and qualified error flags
    always_comb begin
        wr_stb    = reg_en && reg_we;
        rd_stb    = reg_en && !reg_we;
        err_sbe_w = rd_valid && rd_sbe;
        err_mbe_w = rd_valid && rd_mbe;
        cap_en_w  = (err_sbe_w || err_mbe_w) && !frozen_w;
    end

    eic_inject #(
        .DATA_W (DATA_W),
        .CHK_W  (CHK_W),
        .AW     (AW)
    ) u_inj (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_stb    (wr_stb),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .data_in   (wr_data_in),
        .chk_in    (wr_chk_in),
        .data_out  (wr_data_out),
        .chk_out   (wr_chk_out),
        .data_mask (data_mask_w),
        .chk_mask  (chk_mask_w),
        .inj_en    (inj_en_w)
    );

    eic_status #(
        .CNT_W (CNT_W)
    ) u_stat (
        .clk          (clk),
        .rst_n        (rst_n),
        .err_sbe      (err_sbe_w),
        .err_mbe      (err_mbe_w),
        .ev_addr_par  (ev_addr_par),
        .ev_calib     (ev_calib),
        .ev_sel       (ev_sel),
        .det_clr_we   (wr_stb && reg_addr == AW'(OFS_DETECT)),
        .det_clr_mask (reg_wdata),
        .cnt_we       (wr_stb && reg_addr == AW'(OFS_SBE_CNT)),
        .cnt_wdata    (reg_wdata[CNT_W-1:0]),
        .det_q        (det_w),
        .cnt_q        (cnt_w),
        .frozen       (frozen_w),
        .irq          (irq)
    );

    eic_capture #(
        .DATA_W (DATA_W),
        .CHK_W  (CHK_W),
        .ADDR_W (ADDR_W),
        .EXT_W  (EXT_W),
        .ATTR_W (ATTR_W)
    ) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap_en   (cap_en_w),
        .data_in  (rd_data),
        .chk_in   (rd_chk),
        .addr_in  (rd_addr),
        .ext_in   (rd_ext_addr),
        .attr_in  (rd_attr),
        .cap_data (cap_data_w),
        .cap_chk  (cap_chk_w),
        .cap_addr (cap_addr_w),
        .cap_ext  (cap_ext_w),
        .cap_attr (cap_attr_w)
    );

    eic_readmux #(
        .DATA_W (DATA_W),
        .CHK_W  (CHK_W),
        .ADDR_W (ADDR_W),
        .EXT_W  (EXT_W),
        .ATTR_W (ATTR_W),
        .CNT_W  (CNT_W),
        .AW     (AW)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_stb    (rd_stb),
        .reg_addr  (reg_addr),
        .data_mask (data_mask_w),
        .chk_mask  (chk_mask_w),
        .inj_en    (inj_en_w),
        .det_q     (det_w),
        .cnt_q     (cnt_w),
        .cap_data  (cap_data_w),
        .cap_chk   (cap_chk_w),
        .cap_addr  (cap_addr_w),
        .cap_ext   (cap_ext_w),
        .cap_attr  (cap_attr_w),
        .rdata_q   (reg_rdata)
    );

endmodule

// File: rtl/eic_checker.sv
// Module: assertion checker for ecc_inject_capture, attached by bind.
// Observes ports and internal state of the top; drives nothing.
module eic_checker
    import eic_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CHK_W  = 8,
    parameter int ADDR_W = 32,
    parameter int CNT_W  = 8,
    parameter int AW     = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] wr_data_in,
    input logic [CHK_W-1:0]  wr_chk_in,
    input logic [DATA_W-1:0] wr_data_out,
    input logic [CHK_W-1:0]  wr_chk_out,
    input logic              rd_valid,
    input logic              rd_sbe,
    input logic              rd_mbe,
    input logic              reg_en,
    input logic              reg_we,
    input logic [AW-1:0]     reg_addr,
    input logic              irq,
    input logic              inj_en,
    input logic              frozen,
    input logic [REG_W-1:0]  det,
    input logic [CNT_W-1:0]  cnt,
    input logic [ADDR_W-1:0] cap_addr,
    input logic [DATA_W-1:0] cap_data
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic det_wr;
    logic cnt_wr;
    logic any_err;

    assign det_wr  = reg_en && reg_we && reg_addr == AW'(OFS_DETECT);
    assign cnt_wr  = reg_en && reg_we && reg_addr == AW'(OFS_SBE_CNT);
    assign any_err = rd_valid && (rd_sbe || rd_mbe);

    AST_INJ_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
        !inj_en |-> (wr_data_out == wr_data_in && wr_chk_out == wr_chk_in)); // R1

    AST_CAP_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> ($stable(cap_addr) && $stable(cap_data))); // R5

    AST_OVF_ON_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
        (any_err && frozen) |=> det[DET_OVF]); // R5

    AST_SBE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_sbe && !rd_mbe) |=> det[DET_SBE]); // R6

    AST_MBE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && rd_mbe && !det_wr) |=> det[DET_MBE]); // R6

    AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CNT_MAX && !cnt_wr) |=> (cnt == CNT_MAX)); // R7

    AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !det_wr) |=> irq); // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!irq && cnt == '0 && !inj_en)); // R9

endmodule

bind ecc_inject_capture eic_checker #(
    .DATA_W (DATA_W),
    .CHK_W  (CHK_W),
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .AW     (AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_data_in  (wr_data_in),
    .wr_chk_in   (wr_chk_in),
    .wr_data_out (wr_data_out),
    .wr_chk_out  (wr_chk_out),
    .rd_valid    (rd_valid),
    .rd_sbe      (rd_sbe),
    .rd_mbe      (rd_mbe),
    .reg_en      (reg_en),
    .reg_we      (reg_we),
    .reg_addr    (reg_addr),
    .irq         (irq),
    .inj_en      (inj_en_w),
    .frozen      (frozen_w),
    .det         (det_w),
    .cnt         (cnt_w),
    .cap_addr    (cap_addr_w),
    .cap_data    (cap_data_w)
);

// File: tb/ecc_inject_capture_tb.sv
// Bench: behavioural reference model compared on every clock, plus
// directed register reads with literal expected values.
module ecc_inject_capture_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] wr_data_in = '0;
    logic [7:0]  wr_chk_in = '0;
    logic [63:0] wr_data_out;
    logic [7:0]  wr_chk_out;
    logic        rd_valid = 1'b0, rd_sbe = 1'b0, rd_mbe = 1'b0;
    logic [63:0] rd_data = '0;
    logic [7:0]  rd_chk = '0;
    logic [31:0] rd_addr = '0;
    logic [3:0]  rd_ext_addr = '0;
    logic [31:0] rd_attr = '0;
    logic        ev_addr_par = 1'b0, ev_calib = 1'b0, ev_sel = 1'b0;
    logic        reg_en = 1'b0, reg_we = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;

    ecc_inject_capture u_dut (
        .clk(clk), .rst_n(rst_n),
        .wr_data_in(wr_data_in), .wr_chk_in(wr_chk_in),
        .wr_data_out(wr_data_out), .wr_chk_out(wr_chk_out),
        .rd_valid(rd_valid), .rd_sbe(rd_sbe), .rd_mbe(rd_mbe),
        .rd_data(rd_data), .rd_chk(rd_chk), .rd_addr(rd_addr),
        .rd_ext_addr(rd_ext_addr), .rd_attr(rd_attr),
        .ev_addr_par(ev_addr_par), .ev_calib(ev_calib), .ev_sel(ev_sel),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- reference model ----------------
    logic [31:0] m_hi, m_lo, m_det, m_rdata, m_caddr, m_cattr;
    logic [63:0] m_cdata;
    logic [7:0]  m_cm, m_cnt, m_cchk;
    logic [3:0]  m_cext;
    logic        m_en;

    function automatic logic [31:0] m_read(input logic [3:0] a);
        case (a)
            4'd0:  return m_hi;
            4'd1:  return m_lo;
            4'd2:  return {m_en, 23'd0, m_cm};
            4'd3:  return m_det;
            4'd4:  return {24'd0, m_cnt};
            4'd5:  return m_cdata[63:32];
            4'd6:  return m_cdata[31:0];
            4'd7:  return {24'd0, m_cchk};
            4'd8:  return m_caddr;
            4'd9:  return {28'd0, m_cext};
            4'd10: return m_cattr;
            default: return 32'd0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_hi = 0; m_lo = 0; m_det = 0; m_rdata = 0; m_caddr = 0;
            m_cattr = 0; m_cdata = 0; m_cm = 0; m_cnt = 0; m_cchk = 0;
            m_cext = 0; m_en = 0;
        end else begin
            logic [31:0] setv, clrv;
            bit fr, err;
            if (reg_en && !reg_we) m_rdata = m_read(reg_addr);
            fr  = m_det[2] || m_det[3];
            err = rd_valid && (rd_sbe || rd_mbe);
            setv = 0;
            if (rd_valid && rd_mbe) setv[3] = 1;
            else if (rd_valid && rd_sbe) setv[2] = 1;
            if (err && fr) setv[31] = 1;
            setv[8] = ev_addr_par; setv[7] = ev_calib; setv[0] = ev_sel;
            clrv = (reg_en && reg_we && reg_addr == 4'd3) ? (reg_wdata & 32'h8000_018D) : 0;
            if (err && !fr) begin
                m_cdata = rd_data; m_cchk = rd_chk; m_caddr = rd_addr;
                m_cext = rd_ext_addr; m_cattr = rd_attr;
            end
            if (reg_en && reg_we && reg_addr == 4'd4) m_cnt = reg_wdata[7:0];
            else if (rd_valid && rd_sbe && !rd_mbe && m_cnt != 8'hFF) m_cnt = m_cnt + 1;
            m_det = (m_det & ~clrv) | setv;
            if (reg_en && reg_we) begin
                if (reg_addr == 4'd0) m_hi = reg_wdata;
                if (reg_addr == 4'd1) m_lo = reg_wdata;
                if (reg_addr == 4'd2) begin m_en = reg_wdata[31]; m_cm = reg_wdata[7:0]; end
            end
        end
    end

    // Compare every cycle, away from the active edge
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            logic [63:0] ed;
            logic [7:0]  ec;
            ed = m_en ? (wr_data_in ^ {m_hi, m_lo}) : wr_data_in;
            ec = m_en ? (wr_chk_in ^ m_cm) : wr_chk_in;
            check(wr_data_out == ed && wr_chk_out == ec,
                  m_en ? "R2 write path" : "R1 write path", wr_data_out, ed);
            check(reg_rdata == m_rdata, "R3 rdata model", reg_rdata, m_rdata);
            check(irq == (m_det != 0), "R8 irq model", irq, m_det != 0);
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_en = 0; reg_we = 0;
    endtask

    task automatic reg_expect(input logic [3:0] a, input logic [31:0] e, input string tag);
        @(negedge clk);
        reg_en = 1; reg_we = 0; reg_addr = a;
        @(negedge clk);
        reg_en = 0;
        #2;
        check(reg_rdata == e, tag, reg_rdata, e);
    endtask

    task automatic rd_err(input bit s, input bit m, input logic [63:0] d,
                          input logic [7:0] c, input logic [31:0] a,
                          input logic [3:0] x, input logic [31:0] at);
        @(negedge clk);
        rd_valid = 1; rd_sbe = s; rd_mbe = m; rd_data = d; rd_chk = c;
        rd_addr = a; rd_ext_addr = x; rd_attr = at;
        @(negedge clk);
        rd_valid = 0; rd_sbe = 0; rd_mbe = 0;
    endtask

    task automatic pulse_ev(input bit p, input bit c, input bit s);
        @(negedge clk);
        ev_addr_par = p; ev_calib = c; ev_sel = s;
        @(negedge clk);
        ev_addr_par = 0; ev_calib = 0; ev_sel = 0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R9: reset state
        reg_expect(4'd3, 32'h0, "R9 detect after reset");
        reg_expect(4'd4, 32'h0, "R9 count after reset");
        reg_expect(4'd2, 32'h0, "R9 control after reset");
        #1; check(irq == 0, "R9 irq after reset", irq, 0);

        // R1: no injection while disabled
        @(negedge clk); wr_data_in = 64'h0123_4567_89AB_CDEF; wr_chk_in = 8'hA0;
        #2; check(wr_data_out == 64'h0123_4567_89AB_CDEF && wr_chk_out == 8'hA0,
                  "R1 bypass at reset", wr_data_out, 64'h0123_4567_89AB_CDEF);

        // R2/R3: load masks and enable
        reg_write(4'd0, 32'h8000_0001);
        reg_write(4'd1, 32'h0000_0100);
        reg_write(4'd2, 32'h8000_0005);
        #2; check(wr_data_out == 64'h8123_4566_89AB_CCEF, "R2 data corrupted",
                  wr_data_out, 64'h8123_4566_89AB_CCEF);
        check(wr_chk_out == 8'hA5, "R2 check corrupted", wr_chk_out, 8'hA5);
        reg_expect(4'd0, 32'h8000_0001, "R3 upper mask readback");
        reg_expect(4'd1, 32'h0000_0100, "R3 lower mask readback");
        reg_expect(4'd2, 32'h8000_0005, "R3 control readback");
        reg_expect(4'd13, 32'h0, "R3 unmapped reads zero");
        @(negedge clk); wr_data_in = 64'hFFFF_0000_FFFF_0000; wr_chk_in = 8'h0F;
        repeat (3) @(negedge clk);

        // R1: enable off with masks loaded, then all three zero
        reg_write(4'd2, 32'h0000_0005);
        #2; check(wr_data_out == 64'hFFFF_0000_FFFF_0000 && wr_chk_out == 8'h0F,
                  "R1 enable off", wr_data_out, 64'hFFFF_0000_FFFF_0000);
        reg_write(4'd0, 0); reg_write(4'd1, 0); reg_write(4'd2, 0);
        #2; check(wr_data_out == 64'hFFFF_0000_FFFF_0000, "R1 all zero",
                  wr_data_out, 64'hFFFF_0000_FFFF_0000);

        // R4: first error captured
        rd_err(1, 0, 64'h0000_0001_0000_0000, 8'h00, 32'h0100_1000, 4'h3, 32'h3011_2001);
        reg_expect(4'd5, 32'h0000_0001, "R4 capture upper");
        reg_expect(4'd6, 32'h0, "R4 capture lower");
        reg_expect(4'd8, 32'h0100_1000, "R4 capture address");
        reg_expect(4'd9, 32'h3, "R4 capture ext address");
        reg_expect(4'd10, 32'h3011_2001, "R4 capture attributes");
        reg_expect(4'd3, 32'h0000_0004, "R6 single-bit flag");
        reg_expect(4'd4, 32'h1, "R7 count one");
        #1; check(irq == 1, "R8 irq raised", irq, 1);

        // R5: second error while frozen
        rd_err(0, 1, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 32'hDEAD_0000, 4'hF, 32'h1);
        reg_expect(4'd8, 32'h0100_1000, "R5 address frozen");
        reg_expect(4'd7, 32'h0, "R5 check byte frozen");
        reg_expect(4'd3, 32'h8000_000C, "R5 overflow and R6 multi-bit flag");
        reg_expect(4'd4, 32'h1, "R7 multi-bit not counted");

        // R6: other events, W1C
        pulse_ev(1, 0, 0); pulse_ev(0, 1, 0); pulse_ev(0, 0, 1);
        reg_expect(4'd3, 32'h8000_018D, "R6 event bits");
        reg_write(4'd3, 32'h0);
        reg_expect(4'd3, 32'h8000_018D, "R6 write zero keeps");
        reg_write(4'd3, 32'h8000_000C);
        reg_expect(4'd3, 32'h0000_0181, "R6 partial clear");
        #1; check(irq == 1, "R8 irq held", irq, 1);
        reg_write(4'd3, 32'h0000_0181);
        #2; check(irq == 0, "R8 irq released", irq, 0);

        // R10: re-armed capture
        rd_err(1, 0, 64'h1234_5678_9ABC_DEF0, 8'h3C, 32'h0000_0040, 4'h0, 32'h11);
        reg_expect(4'd6, 32'h9ABC_DEF0, "R10 new capture lower");
        reg_expect(4'd7, 32'h3C, "R10 new capture check");
        reg_expect(4'd4, 32'h2, "R7 count two");

        // R7: saturation then clear
        for (int i = 0; i < 260; i++) begin
            @(negedge clk); rd_valid = 1; rd_sbe = 1;
        end
        @(negedge clk); rd_valid = 0; rd_sbe = 0;
        reg_expect(4'd4, 32'hFF, "R7 saturated");
        reg_expect(4'd6, 32'h9ABC_DEF0, "R5 capture kept under load");
        reg_write(4'd4, 32'h0);
        reg_expect(4'd4, 32'h0, "R7 cleared by zero write");
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule